// File: doc/BRIEF.md
# SPI Master with Word-Selected Chip Select

This block is a serial peripheral interface master for four slave devices. Each word travels out on `mosi`, most significant bit first, while the reply is collected from `miso`. The chip select for a word comes from one of two places, chosen by a mode bit. In fixed mode it is a select field held in the mode register, so every word goes to the same slave until that register is rewritten. In variable mode it is a 4-bit field packed into each 32-bit word written for transmission, so consecutive words may go to different slaves without any register rewrite.

Each of the four chip selects has its own length setting, from 8 to 16 bits. The number of bits shifted for a word follows the setting of the slave that word addresses. A release flag in the transmit word raises the chip select once that word is done. Without the flag, the select stays low, and a following word to the same slave continues under it. A word to a different slave first gets a short idle gap with every select high. The serial clock idles low, data changes while the clock is low, and `miso` is sampled on the rising edge.

Software-facing behaviour is reduced to a write port and two flags. The transmit-empty flag tells the writer when the holding register may take the next word. The receive-full flag, together with an acknowledge pulse, hands each received word to the reader.

Top module: `spi_psel_master`

## Requirements
- R1: After reset, `cs_n` is 4'hF, `sclk` and `mosi` are 0, `tdre` is 1, `rdrf` is 0 and `rx_data` is 0.
- R2: Writes use `wr_addr`: 0 = mode (bit 0: 1 selects variable mode; bits [19:16]: fixed select field), 1 = transmit word, 4 to 7 = length setting of chip select 0 to 3 in bits [3:0]. In a transmit word, data is bits [15:0], the select field is bits [19:16] and the release flag is bit 24. All other bits, and data bits above the word length, have no effect.
- R3: A select field drives low the `cs_n` line whose index is the lowest zero bit of the field. For example, 4'b1110 selects line 0 and 4'b0101 selects line 1. The value 4'b1111 selects no line: the word is still shifted, with `cs_n` all high, using the length setting of line 0. At most one `cs_n` line is ever low.
- R4: In fixed mode the select field of the mode register applies to every word, and bits [19:16] of the transmit word have no effect. The mode and select are taken when a word enters the shifter.
- R5: A length setting c gives 8+c bits for c up to 8 and 16 bits for any larger c. The word length is that of the selected line.
- R6: Data leaves `mosi` most significant bit first. `mosi` changes only while `sclk` is low, `miso` is sampled at each rising `sclk` edge, and `cs_n` is stable while `sclk` is high. `rx_data` holds the received bits right-aligned with zeros above them.
- R7: When a word carries the release flag, `cs_n` goes to 4'hF in the cycle after its last falling `sclk` edge. Without the flag, the line stays low after the word, and a next word to the same line starts without raising it.
- R8: If a line is held low and the next word selects a different field, all `cs_n` lines are high for exactly HALF clock cycles before the new line goes low. `cs_n` never switches directly from one low line to another.
- R9: A transmit write clears `tdre`. `tdre` sets again when the held word moves into the shifter, which happens in the cycle after the write if the shifter is idle.
- R10: `rdrf` sets in the cycle after a word's last bit completes, with the word in `rx_data`. An `rx_ack` pulse clears it, and a completion in the same cycle takes priority.
- R11: Each `sclk` high phase lasts HALF clock cycles. The first rising edge comes HALF cycles after a `cs_n` line goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rx_ack | input | 1 | Reader has taken `rx_data`; clears `rdrf` |
| tdre | output | 1 | Transmit holding register empty |
| rdrf | output | 1 | Received word available |
| rx_data | output | 16 | Last received word, right-aligned |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The hardest situation to reach is a held chip select that meets a word for a different slave. This only happens when a word without the release flag is followed by a word whose select field, or the fixed select in the mode register, points elsewhere. The stimulus builds this on purpose. It leaves line 2 held in fixed mode, switches to variable mode and sends a word for line 1. It then chains words for line 3, line 0, the no-select value and a multi-zero field, back to back through the holding register. Along the way it measures the all-high gap and the number of bits under each select. A behavioural slave returns a position-dependent bit pattern, so the reply of every word can be predicted.

// File: rtl/spi_psel_master.sv
module spi_psel_master #(
  parameter int HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rx_ack,
  output logic        tdre,
  output logic        rdrf,
  output logic [15:0] rx_data,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  cs_n
);
  localparam int TW = (HALF < 2) ? 1 : $clog2(HALF);
  localparam logic [TW-1:0] TEND = TW'(HALF - 1);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_LOW, S_HIGH} st_t;

  function automatic logic [1:0] first_low(input logic [3:0] s);
    first_low = 2'd0;
    for (int i = 3; i >= 0; i--) if (!s[i]) first_low = 2'(i);
  endfunction

  function automatic logic [3:0] sel_lines(input logic [3:0] s);
    sel_lines = (&s) ? 4'hF : ~(4'b0001 << first_low(s));
  endfunction

  function automatic logic [4:0] width_of(input logic [3:0] c);
    width_of = (c > 4'd8) ? 5'd16 : 5'd8 + {1'b0, c};
  endfunction

  logic        var_mode;
  logic [3:0]  fix_sel;
  logic [3:0]  len_cfg [4];
  logic        hold_full, hold_last;
  logic [15:0] hold_data;
  logic [3:0]  hold_sel;
  st_t         st;
  logic [TW-1:0] tmr;
  logic [15:0] tx_sh, rx_sh;
  logic [4:0]  bits_left;
  logic [3:0]  act_sel, held_sel;
  logic        act_last, held;
  logic        unused_bits;

  wire tx_wr = wr_en && (wr_addr == 3'd1);
  wire load = (st == S_IDLE) && hold_full;
  wire tick = (tmr == TEND);
  wire word_done = (st == S_HIGH) && tick && (bits_left == 5'd1);
  wire [3:0] ld_sel = var_mode ? hold_sel : fix_sel;
  wire [4:0] ld_len = width_of(len_cfg[first_low(ld_sel)]);

  assign tdre = !hold_full;
  assign mosi = tx_sh[15];
  assign unused_bits = ^{wr_data[31:25], wr_data[23:20]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      var_mode  <= 1'b0;
      fix_sel   <= 4'hF;
      for (int i = 0; i < 4; i++) len_cfg[i] <= 4'd0;
      hold_full <= 1'b0;
      hold_last <= 1'b0;
      hold_data <= 16'd0;
      hold_sel  <= 4'hF;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin
            var_mode <= wr_data[0];
            fix_sel  <= wr_data[19:16];
          end
          3'd1: begin
            hold_data <= wr_data[15:0];
            hold_sel  <= wr_data[19:16];
            hold_last <= wr_data[24];
          end
          3'd4, 3'd5, 3'd6, 3'd7: len_cfg[wr_addr[1:0]] <= wr_data[3:0];
          default: ;
        endcase
      end
      if (tx_wr) hold_full <= 1'b1;
      else if (load) hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      tx_sh     <= 16'd0;
      rx_sh     <= 16'd0;
      bits_left <= 5'd0;
      act_sel   <= 4'hF;
      act_last  <= 1'b0;
      held      <= 1'b0;
      held_sel  <= 4'hF;
      sclk      <= 1'b0;
      cs_n      <= 4'hF;
      rdrf      <= 1'b0;
      rx_data   <= 16'd0;
    end else begin
      if (word_done) rdrf <= 1'b1;
      else if (rx_ack) rdrf <= 1'b0;

      if (st != S_IDLE) tmr <= tick ? '0 : tmr + 1'b1;

      case (st)
        S_IDLE: if (load) begin
          tmr       <= '0;
          tx_sh     <= hold_data << (5'd16 - ld_len);
          rx_sh     <= 16'd0;
          bits_left <= ld_len;
          act_sel   <= ld_sel;
          act_last  <= hold_last;
          if (held && held_sel != ld_sel) begin
            cs_n <= 4'hF;
            held <= 1'b0;
            st   <= S_GAP;
          end else begin
            cs_n <= sel_lines(ld_sel);
            st   <= S_LOW;
          end
        end
        S_GAP: if (tick) begin
          cs_n <= sel_lines(act_sel);
          st   <= S_LOW;
        end
        S_LOW: if (tick) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[14:0], miso};
          st    <= S_HIGH;
        end
        S_HIGH: if (tick) begin
          sclk <= 1'b0;
          if (bits_left == 5'd1) begin
            rx_data <= rx_sh;
            st      <= S_IDLE;
            if (act_last) begin
              cs_n <= 4'hF;
              held <= 1'b0;
            end else begin
              held     <= !(&act_sel);
              held_sel <= act_sel;
            end
          end else begin
            tx_sh     <= tx_sh << 1;
            bits_left <= bits_left - 5'd1;
            st        <= S_LOW;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_one_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  p_cs_quiet_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(cs_n));
  p_mosi_low_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !sclk);
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && act_last) |=> (cs_n == 4'hF));
  p_no_direct_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n) |-> (cs_n == 4'hF || $past(cs_n) == 4'hF));
  p_write_fills_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tdre);
  p_done_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> rdrf);
endmodule

// File: tb/tb_spi_psel_master.sv
module tb_spi_psel_master;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rx_ack = 1'b0, miso = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [31:0] wr_data = 32'd0;
  wire tdre, rdrf, sclk, mosi;
  wire [15:0] rx_data;
  wire [3:0]  cs_n;

  spi_psel_master #(.HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_ack(rx_ack), .tdre(tdre), .rdrf(rdrf), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit b_var = 1'b0;
  logic [3:0] b_fix = 4'hF;
  int b_len [4] = '{8, 8, 8, 8};
  logic [3:0] q_cs [$];
  int q_len [$], q_data [$], rx_q [$];
  int rise_k = 0, nbits = 0, acc_tx = 0, acc_rx = 0;
  int f_run = 0, last_gap = -1, since_as = -1, hi_run = 0;
  logic prev_sclk = 1'b0;
  logic [3:0] prev_cs = 4'hF;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit resp(int k);
    return ((k * 13 + 7) % 11) > 4;
  endfunction

  function automatic logic [3:0] pick(logic [3:0] s);
    for (int i = 0; i < 4; i++) if (!s[i]) return 4'hF ^ (4'h1 << i);
    return 4'hF;
  endfunction

  function automatic int len_for(logic [3:0] s);
    for (int i = 0; i < 4; i++) if (!s[i]) return b_len[i];
    return b_len[0];
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (cs_n != 4'hF && prev_cs != 4'hF && cs_n != prev_cs)
      chk(0, "R8 direct select switch", cs_n, prev_cs);
    if (since_as >= 0) since_as++;
    if (cs_n == 4'hF) f_run++;
    else begin
      if (prev_cs == 4'hF) begin
        last_gap = f_run;
        since_as = 0;
      end
      f_run = 0;
    end
    if (sclk) hi_run++;
    else if (prev_sclk) begin
      chk(hi_run == HALF, "R11 sclk high length", hi_run, HALF);
      hi_run = 0;
    end
    if (sclk && !prev_sclk) begin
      if (q_cs.size() == 0) chk(0, "R6 rising edge with no word", 0, 1);
      else begin
        chk(cs_n == q_cs[0], "R3 select during bit", cs_n, q_cs[0]);
        if (since_as >= 0) chk(since_as == HALF, "R11 select to first edge", since_as, HALF);
        since_as = -1;
        acc_tx = (acc_tx << 1) | int'(mosi);
        acc_rx = (acc_rx << 1) | int'(resp(rise_k));
        rise_k++;
        nbits++;
        if (nbits == q_len[0]) begin
          chk(acc_tx == (q_data[0] & ((1 << q_len[0]) - 1)), "R5 R6 mosi word",
              acc_tx, q_data[0] & ((1 << q_len[0]) - 1));
          rx_q.push_back(acc_rx);
          void'(q_cs.pop_front());
          void'(q_len.pop_front());
          void'(q_data.pop_front());
          nbits = 0; acc_tx = 0; acc_rx = 0;
        end
      end
    end
    if (rx_ack) begin
      chk(!rdrf, "R10 ack clears rdrf", rdrf, 0);
      rx_ack = 1'b0;
    end else if (rdrf) begin
      if (rx_q.size() == 0) chk(0, "R10 rdrf with no word", 1, 0);
      else begin
        chk(rx_data == 16'(rx_q[0]), "R6 R10 received word", rx_data, rx_q[0]);
        void'(rx_q.pop_front());
      end
      rx_ack = 1'b1;
    end
    prev_sclk = sclk;
    prev_cs = cs_n;
    miso = resp(rise_k);
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input logic [31:0] w);
    logic [3:0] s;
    @(negedge clk);
    while (!tdre) @(negedge clk);
    s = b_var ? w[19:16] : b_fix;
    q_cs.push_back(pick(s));
    q_len.push_back(len_for(s));
    q_data.push_back(int'(w[15:0]));
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (q_cs.size() > 0 || rx_q.size() > 0 || rdrf || rx_ack);
    repeat (HALF + 3) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    miso = resp(0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 4'hF, "R1 cs_n", cs_n, 4'hF);
    chk(!sclk && !mosi, "R1 sclk mosi", {sclk, mosi}, 0);
    chk(tdre && !rdrf, "R1 flags", {tdre, rdrf}, 2);
    chk(rx_data == 16'd0, "R1 rx_data", rx_data, 0);
    rst_n = 1'b1;
    // R2 R5 length settings, upper bits of the setting write ignored
    wr(3'd4, 32'h0000_0000); b_len[0] = 8;
    wr(3'd5, 32'h0000_0008); b_len[1] = 16;
    wr(3'd6, 32'h0000_0004); b_len[2] = 12;
    wr(3'd7, 32'hFFFF_FF0D); b_len[3] = 16;
    // R4 fixed mode on line 0, word select field ignored
    wr(3'd0, 32'h000E_0000); b_fix = 4'hE; b_var = 1'b0;
    send(32'hA0F7_C3A5);
    chk(!tdre, "R9 write clears tdre", tdre, 0);
    @(negedge clk);
    chk(tdre, "R9 word moved to shifter", tdre, 1);
    send(32'h00E1_005A);
    drain();
    chk(cs_n == 4'hE, "R7 line held without release", cs_n, 4'hE);
    send(32'h0100_0081);
    drain();
    chk(cs_n == 4'hF, "R7 release after flagged word", cs_n, 4'hF);
    // R4 rewrite mode register to talk to line 2
    wr(3'd0, 32'h000B_0000); b_fix = 4'hB;
    send(32'h0000_0ABC);
    drain();
    chk(cs_n == 4'hB, "R4 fixed select line 2", cs_n, 4'hB);
    // R8 variable mode word to another line while line 2 held
    wr(3'd0, 32'h0000_0001); b_var = 1'b1;
    send(32'h00FD_1234);
    drain();
    chk(last_gap == HALF, "R8 idle gap length", last_gap, HALF);
    chk(cs_n == 4'hD, "R3 variable select line 1", cs_n, 4'hD);
    // R3 R5 back-to-back words to several lines, no-select and multi-zero fields
    send(32'hFE07_BEEF);
    send(32'h000E_F0F0);
    send(32'h010F_00C3);
    send(32'h0105_8001);
    drain();
    chk(cs_n == 4'hF, "R7 final release", cs_n, 4'hF);
    chk(rise_k == 8 + 8 + 8 + 12 + 16 + 16 + 8 + 8 + 16, "R5 total bits shifted", rise_k, 100);
    summary();
  end
endmodule